// File: doc/BRIEF.md
# Slow-Peripheral Bus Glue Controller

This block joins a processor whose data-memory accesses normally finish in a single clock to a slower memory-mapped serial controller with two channels. It recognises accesses to a four-register window from the upper address bits and the read and write strobes, and drives the peripheral's select line. While a peripheral access is in progress, it holds the processor's acknowledge low for a set number of wait states. It also reshapes the processor's write strobe so that write data has settled before the peripheral's write line falls.

The two lowest address bits go straight to the peripheral as its data/command select and its channel select. The serial controller has no reset pin. A one-clock request input instead drives the peripheral's select, read and write lines low together for a set number of clocks. Every access to another address keeps acknowledge high, so other memory runs with no wait states.

Top module: `glue_periph_bridge`

## Requirements
- R1: `per_cs_n` is low (outside a reset pulse) exactly when `bus_addr[ADDR_W-1:2]` equals `PERIPH_BASE` and at least one of `dm_rd_n`, `dm_wr_n` is low. With defaults, the window is 0xF000 to 0xF003.
- R2: In the first cycle of a peripheral access, `dm_ack` is low. It stays low for `WAIT_CYC` cycles in total (default 4). It rises in cycle `WAIT_CYC` counted from 0, and stays high until the access ends. An access that ends early restarts the count on the next access.
- R3: When no peripheral access is in progress, `dm_ack` is high.
- R4: On a peripheral write, `per_wr_n` stays high in the cycle where `dm_wr_n` falls. It goes low after the next rising clock edge.
- R5: `per_wr_n` returns high in the same cycle that `dm_wr_n` returns high, without waiting for a clock edge.
- R6: `per_rd_n` is low exactly when `per_cs_n` is decoded for an access and `dm_rd_n` is low, with no clock delay.
- R7: `per_dc` always equals `bus_addr[0]`, and `per_ch` always equals `bus_addr[1]`.
- R8: When `prst_req` is sampled high at a rising edge and no pulse is running, `per_cs_n`, `per_rd_n` and `per_wr_n` all go low together. They stay low for `RST_CYC` cycles (default 2) and then return high.
- R9: A `prst_req` that is sampled high while a pulse is already running is ignored. The pulse is not lengthened.
- R10: While `rst_n` is low and after it is released, with idle strobes, all peripheral strobes are high and `dm_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | ADDR_W | Processor data-memory address |
| dm_rd_n | input | 1 | Processor data-memory read strobe, active low |
| dm_wr_n | input | 1 | Processor data-memory write strobe, active low |
| prst_req | input | 1 | Request for a peripheral reset pulse |
| per_cs_n | output | 1 | Peripheral select, active low |
| per_rd_n | output | 1 | Peripheral read line, active low |
| per_wr_n | output | 1 | Peripheral write line, active low, delayed on assertion |
| per_dc | output | 1 | Peripheral data/command select |
| per_ch | output | 1 | Peripheral channel select |
| dm_ack | output | 1 | Data-memory acknowledge back to the processor |

## Verification
The results arrive at different times:
- Select, read line, address pass-through and write release are combinational, so each is due in the same cycle as the input change.
- The write line falls one edge after the strobe.
- Acknowledge rises `WAIT_CYC` edges after the access starts.
- The reset trio goes low one edge after the request is sampled, for `RST_CYC` cycles.

The bench changes inputs on the falling clock edge. Each expected vector is tagged with the cycle it is due in. All outputs are sampled shortly before the next rising edge, so every registered result is compared in the cycle its edge count puts it in.

// File: rtl/glue_pkg.sv
package glue_pkg;
  // Width needed to hold the values 0..n, never less than one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

  // Value loaded into the wait counter when an access begins.
  function automatic int unsigned wait_load(input int unsigned waits);
    return (waits == 0) ? 0 : waits - 1;
  endfunction
endpackage

// File: rtl/glue_wait_gen.sv
module glue_wait_gen #(
  parameter int unsigned WAIT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic dm_ack
);
  import glue_pkg::*;
  localparam int unsigned CW = cnt_width(WAIT_CYC);

  logic          active;
  logic [CW-1:0] cnt;
  logic          start;

  assign start = hit & ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!hit) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= CW'(wait_load(WAIT_CYC));
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign dm_ack = ~hit | (active & (cnt == '0));
endmodule

// File: rtl/glue_wr_shaper.sv
module glue_wr_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic dm_wr_n,
  output logic wr_line_n
);
  logic wr_dly_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_dly_n <= 1'b1;
    else        wr_dly_n <= ~(hit & ~dm_wr_n);
  end

  // Assertion waits one edge; release follows the raw strobe at once.
  assign wr_line_n = wr_dly_n | dm_wr_n | ~hit;
endmodule

// File: rtl/glue_reset_pulse.sv
module glue_reset_pulse #(
  parameter int unsigned RST_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prst_req,
  output logic rst_act
);
  import glue_pkg::*;
  localparam int unsigned CW = cnt_width(RST_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
    else if (prst_req)      cnt <= CW'(RST_CYC);
  end

  assign rst_act = (cnt != '0);
endmodule

// File: rtl/glue_periph_bridge.sv
module glue_periph_bridge #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-3:0] PERIPH_BASE = 14'h3C00,
  parameter int unsigned WAIT_CYC = 4,
  parameter int unsigned RST_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              dm_rd_n,
  input  logic              dm_wr_n,
  input  logic              prst_req,
  output logic              per_cs_n,
  output logic              per_rd_n,
  output logic              per_wr_n,
  output logic              per_dc,
  output logic              per_ch,
  output logic              dm_ack
);
  logic hit;
  logic rst_act;
  logic wr_line_n;

  assign hit = (bus_addr[ADDR_W-1:2] == PERIPH_BASE) & (~dm_rd_n | ~dm_wr_n);

  glue_wait_gen #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .hit(hit), .dm_ack(dm_ack)
  );

  glue_wr_shaper u_wr (
    .clk(clk), .rst_n(rst_n), .hit(hit), .dm_wr_n(dm_wr_n), .wr_line_n(wr_line_n)
  );

  glue_reset_pulse #(.RST_CYC(RST_CYC)) u_rst (
    .clk(clk), .rst_n(rst_n), .prst_req(prst_req), .rst_act(rst_act)
  );

  assign per_cs_n = ~(hit | rst_act);
  assign per_rd_n = ~((hit & ~dm_rd_n) | rst_act);
  assign per_wr_n = wr_line_n & ~rst_act;
  assign per_dc   = bus_addr[0];
  assign per_ch   = bus_addr[1];
endmodule

// File: rtl/glue_periph_bridge_chk.sv
module glue_periph_bridge_chk #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WAIT_CYC = 4,
  parameter int unsigned RST_CYC  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              dm_rd_n,
  input logic              dm_wr_n,
  input logic              per_cs_n,
  input logic              per_rd_n,
  input logic              per_wr_n,
  input logic              per_dc,
  input logic              per_ch,
  input logic              dm_ack,
  input logic              hit,
  input logic              rst_act
);
  int unsigned hold_cnt;
  int unsigned run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= 0;
      run_cnt  <= 0;
    end else begin
      hold_cnt <= hit ? ((hold_cnt == 32'hFFFF_FFFF) ? hold_cnt : hold_cnt + 1) : 0;
      run_cnt  <= rst_act ? run_cnt + 1 : 0;
    end
  end

  AST_CS_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_cs_n && !rst_act) |-> (!dm_rd_n || !dm_wr_n)); // R1
  AST_ACK_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !$past(hit)) |-> !dm_ack); // R2
  AST_ACK_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dm_ack) |-> (hold_cnt >= WAIT_CYC)); // R2
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> dm_ack); // R3
  AST_WR_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_act && !per_wr_n) |-> !$past(dm_wr_n)); // R4
  AST_WR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_wr_n && !rst_act) |-> per_wr_n); // R5
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_rd_n && !rst_act) |-> per_rd_n); // R6
  AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (per_dc == bus_addr[0]) && (per_ch == bus_addr[1])); // R7
  AST_RST_TRIO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |-> (!per_cs_n && !per_rd_n && !per_wr_n)); // R8
  AST_RST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    rst_act |-> (run_cnt < RST_CYC)); // R9
endmodule

bind glue_periph_bridge glue_periph_bridge_chk #(
  .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC), .RST_CYC(RST_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .dm_rd_n(dm_rd_n),
  .dm_wr_n(dm_wr_n), .per_cs_n(per_cs_n), .per_rd_n(per_rd_n),
  .per_wr_n(per_wr_n), .per_dc(per_dc), .per_ch(per_ch), .dm_ack(dm_ack),
  .hit(hit), .rst_act(rst_act)
);

// File: tb/glue_periph_bridge_tb.sv
module glue_periph_bridge_tb_top;
  localparam int PERIOD = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic        dm_rd_n, dm_wr_n, prst_req;
  logic        per_cs_n, per_rd_n, per_wr_n, per_dc, per_ch, dm_ack;

  typedef struct {
    int         due;
    logic [5:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  glue_periph_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .dm_rd_n(dm_rd_n),
    .dm_wr_n(dm_wr_n), .prst_req(prst_req), .per_cs_n(per_cs_n),
    .per_rd_n(per_rd_n), .per_wr_n(per_wr_n), .per_dc(per_dc),
    .per_ch(per_ch), .dm_ack(dm_ack)
  );

  initial forever #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Expected vector: {cs_n, rd_n, wr_n, ack, ch, dc}
  function automatic logic [5:0] ev(input logic cs, rd, wr, ack, input logic [15:0] a);
    return {cs, rd, wr, ack, a[1], a[0]};
  endfunction

  task automatic step(input logic [15:0] a, input logic rd, wr, req,
                      input logic [5:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; dm_rd_n = rd; dm_wr_n = wr; prst_req = req;
    it.due = cyc; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: samples just before the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/2 - 2);
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        logic [5:0] act;
        it  = q.pop_front();
        act = {per_cs_n, per_rd_n, per_wr_n, dm_ack, per_ch, per_dc};
        n_vec++;
        if (it.due != cyc || act !== it.exp) begin
          n_bad++;
          $display("FAIL %s cycle %0d: actual %b expected %b", it.tag, it.due, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; dm_rd_n = 1'b1; dm_wr_n = 1'b1; prst_req = 1'b0;
    // R10: reset held and released
    step(16'h0000, 1, 1, 0, ev(1,1,1,1,16'h0000), "R10");
    step(16'h0000, 1, 1, 0, ev(1,1,1,1,16'h0000), "R10");
    rst_n = 1'b1;
    step(16'h0000, 1, 1, 0, ev(1,1,1,1,16'h0000), "R10");
    // R1 R3: read outside window
    step(16'h0100, 0, 1, 0, ev(1,1,1,1,16'h0100), "R1_R3");
    // R2 R6 R7: read at F002, ack after four waits
    for (int k = 0; k < 5; k++)
      step(16'hF002, 0, 1, 0, ev(0,0,1,(k >= 4),16'hF002), "R2_R6_R7");
    step(16'hF002, 1, 1, 0, ev(1,1,1,1,16'hF002), "R6_R3");
    // R2: held access keeps ack high
    for (int k = 0; k < 7; k++)
      step(16'hF003, 0, 1, 0, ev(0,0,1,(k >= 4),16'hF003), "R2");
    step(16'h0000, 1, 1, 0, ev(1,1,1,1,16'h0000), "R3");
    // R2: early end then restart of count
    for (int k = 0; k < 2; k++)
      step(16'hF000, 0, 1, 0, ev(0,0,1,0,16'hF000), "R2");
    step(16'h0000, 1, 1, 0, ev(1,1,1,1,16'h0000), "R3");
    for (int k = 0; k < 5; k++)
      step(16'hF000, 0, 1, 0, ev(0,0,1,(k >= 4),16'hF000), "R2");
    step(16'h0000, 1, 1, 0, ev(1,1,1,1,16'h0000), "R3");
    // R4: delayed write line
    step(16'hF001, 1, 0, 0, ev(0,1,1,0,16'hF001), "R4");
    for (int k = 1; k < 5; k++)
      step(16'hF001, 1, 0, 0, ev(0,1,0,(k >= 4),16'hF001), "R4_R2");
    // R5: immediate release
    step(16'hF001, 1, 1, 0, ev(1,1,1,1,16'hF001), "R5");
    // R1 R3: write outside window
    step(16'h1235, 1, 0, 0, ev(1,1,1,1,16'h1235), "R1_R3");
    step(16'h0000, 1, 1, 0, ev(1,1,1,1,16'h0000), "R3");
    // R8: reset pulse
    step(16'h0000, 1, 1, 1, ev(1,1,1,1,16'h0000), "R8");
    step(16'h0000, 1, 1, 0, ev(0,0,0,1,16'h0000), "R8");
    step(16'h0000, 1, 1, 0, ev(0,0,0,1,16'h0000), "R8");
    step(16'h0000, 1, 1, 0, ev(1,1,1,1,16'h0000), "R8");
    // R9: request during a running pulse is ignored
    step(16'h0000, 1, 1, 1, ev(1,1,1,1,16'h0000), "R9");
    step(16'h0000, 1, 1, 1, ev(0,0,0,1,16'h0000), "R9");
    step(16'h0000, 1, 1, 1, ev(0,0,0,1,16'h0000), "R9");
    step(16'h0000, 1, 1, 0, ev(1,1,1,1,16'h0000), "R9");
    // R7: pass-through while idle
    step(16'h7772, 1, 1, 0, ev(1,1,1,1,16'h7772), "R7");
    step(16'h7771, 1, 1, 0, ev(1,1,1,1,16'h7771), "R7");
    @(negedge clk);
    @(negedge clk);
    #(PERIOD/2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule